// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter. It decides when the analog front end samples, and which of ten sources it samples. It then walks an 8-bit trial code down from the most significant bit and keeps or drops each bit according to a single comparator input. The finished code goes into a result register. A host fetches that register with a read strobe and can have it shifted right by up to six places on the way out.

A conversion is requested by a software strobe or by one of several external event lines, chosen by a source select. A conversion either runs once and then parks the converter in power-down, or repeats back to back until free-running is switched off. All sequencing moves on a clock enable from a programmable divider. The sample window is a programmable number of those enables. A cancel strobe throws away the conversion in flight and begins sampling again.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The divider produces one enable every `div_ratio`+1 clocks. Sequencing advances only on enables. From the clock in which `sample_en` rises to the clock in which `done_pulse` rises there are exactly (`sample_len`+9)·(`div_ratio`+1)+1 clocks.
- R2: `chan_out` takes `chan_sel` when a request is accepted, and again at each free-running restart. Indices 0–7 are external inputs and 8–9 are internal. A request for index 10–15 selects channel 9.
- R3: The trial code starts at 0x80. On each enable the bit under test is kept if `cmp_in` is 1 (input ≥ DAC) and cleared otherwise, and the next lower bit is then set. The result is the input level for an ideal comparator.
- R4: `sample_en` stays high for exactly (`sample_len`+1)·(`div_ratio`+1) clocks, and `dac_code` is 0 throughout that time.
- R5: On completion, `done_pulse` is high for exactly one clock and `data_ready` is set in that same clock.
- R6: One clock after a clock with `rd_en` high, `rd_data` holds the result shifted right by `scale` places with zeros filling from the top. Scale values 7 and above act as 6. `rd_en` clears `data_ready`, unless a completion sets it in the same clock.
- R7: In single mode each accepted request gives one conversion. With `free_run` high, a new sample phase starts in the clock after each completion, without a request.
- R8: `trig_src` 0 selects `sw_start`, and `trig_src` k (1–3) selects `ext_trig[k-1]`. Pulses on the sources that are not selected have no effect.
- R9: A request that arrives while `busy` is high is ignored.
- R10: A `cancel` during sampling or conversion sends the sequencer back to the start of sampling on the next enable, with no completion and no change to the result. A `cancel` while idle has no effect.
- R11: `pwr_down` is 1 out of reset. It clears when a request is accepted, sets after every single-mode completion, and stays 0 while free-running.
- R12: After reset, `busy`, `sample_en`, `done_pulse`, `data_ready`, `dac_code`, `chan_out` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_ratio | input | 8 | Divider setting; enable period is value+1 clocks |
| sample_len | input | 4 | Sample window is value+1 enables |
| chan_sel | input | 4 | Requested channel index |
| free_run | input | 1 | 1 = back-to-back conversions, 0 = single |
| trig_src | input | 2 | Request source select |
| sw_start | input | 1 | Software request strobe |
| ext_trig | input | 3 | External event request lines |
| cancel | input | 1 | Abort and restart strobe |
| cmp_in | input | 1 | Comparator: 1 when input ≥ DAC |
| rd_en | input | 1 | Result read strobe |
| scale | input | 3 | Right shift applied on read |
| chan_out | output | 4 | Channel select to the multiplexer |
| sample_en | output | 1 | Sample-and-hold enable |
| dac_code | output | 8 | Trial code to the DAC |
| pwr_down | output | 1 | Analog power-down |
| busy | output | 1 | Request pending or conversion running |
| done_pulse | output | 1 | One-clock completion flag |
| data_ready | output | 1 | Unread result available |
| rd_data | output | 8 | Scaled result |

## Verification
The timing assertions assume that `div_ratio` and `sample_len` hold still while a conversion runs. The bench changes them only when `busy` is low. The comparator is a behavioural level compare against `dac_code` with no delay, so `cmp_in` is settled at every enable. The modelled input level changes only during sampling or while idle, so each result can be predicted exactly. Strobes are single-clock pulses driven between edges.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_W     = 8;
    localparam int NUM_CH    = 10;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int BIT_W     = $clog2(RES_W);
    localparam int SCALE_W   = 3;
    localparam logic [SCALE_W-1:0] MAX_SCALE = SCALE_W'(6);
    localparam logic [CH_W-1:0]    LAST_CH   = CH_W'(NUM_CH - 1);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_DONE    = 2'd3
    } sar_state_e;

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] value;
    } sar_result_t;

    function automatic logic [CH_W-1:0] clamp_chan(input logic [CH_W-1:0] c);
        return (c > LAST_CH) ? LAST_CH : c;
    endfunction

    function automatic logic [RES_W-1:0] scale_shift(input logic [RES_W-1:0] v,
                                                      input logic [SCALE_W-1:0] s);
        logic [SCALE_W-1:0] eff;
        eff = (s > MAX_SCALE) ? MAX_SCALE : s;
        return v >> eff;
    endfunction

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= div_ratio) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R1: with a non-zero ratio, enables never come in adjacent clocks
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && div_ratio != '0) |=> !tick);

endmodule

// File: rtl/sar_trig_sel.sv
module sar_trig_sel #(
    parameter int NUM_EXT = 3,
    parameter int SRC_W   = $clog2(NUM_EXT + 1)
) (
    input  logic [SRC_W-1:0]   trig_src,
    input  logic               sw_start,
    input  logic [NUM_EXT-1:0] ext_trig,
    output logic               start_req
);
    logic [NUM_EXT:0] srcs;

    assign srcs[0] = sw_start;

    generate
        for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
            assign srcs[g+1] = ext_trig[g];
        end
    endgenerate

    always_comb begin
        start_req = 1'b0;
        for (int k = 0; k <= NUM_EXT; k++) begin
            if (int'(trig_src) == k) start_req = srcs[k];
        end
    end

endmodule

// File: rtl/sar_core_fsm.sv
module sar_core_fsm
    import sar_seq_pkg::*;
#(
    parameter int SAMP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start_req,
    input  logic              cancel_req,
    input  logic              free_run,
    input  logic [SAMP_W-1:0] sample_len,
    input  logic [CH_W-1:0]   chan_req,
    input  logic              cmp_in,
    output sar_state_e        state_o,
    output logic [RES_W-1:0]  trial_code,
    output logic [CH_W-1:0]   chan_o,
    output logic              pwr_down,
    output logic              pending,
    output sar_result_t       done_res
);
    sar_state_e        state_q;
    logic [SAMP_W-1:0] cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [RES_W-1:0]  sar_q;
    logic              cpend_q;
    logic              cancel_now;
    logic [RES_W-1:0]  kept;

    assign cancel_now = cpend_q || cancel_req;

    always_comb begin
        kept = sar_q;
        if (!cmp_in) kept[bit_q] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            bit_q    <= '0;
            sar_q    <= '0;
            cpend_q  <= 1'b0;
            pending  <= 1'b0;
            chan_o   <= '0;
            pwr_down <= 1'b1;
        end else begin
            if (state_q == ST_IDLE && start_req && !pending) begin
                pending  <= 1'b1;
                pwr_down <= 1'b0;
                chan_o   <= chan_req;
            end
            if ((state_q == ST_SAMPLE || state_q == ST_CONVERT) && cancel_req)
                cpend_q <= 1'b1;

            unique case (state_q)
                ST_IDLE: begin
                    if (tick && pending) begin
                        state_q <= ST_SAMPLE;
                        cnt_q   <= '0;
                        sar_q   <= '0;
                        pending <= 1'b0;
                    end
                end
                ST_SAMPLE: begin
                    if (tick) begin
                        if (cancel_now) begin
                            cnt_q   <= '0;
                            cpend_q <= 1'b0;
                        end else if (cnt_q == sample_len) begin
                            state_q <= ST_CONVERT;
                            bit_q   <= BIT_W'(RES_W - 1);
                            sar_q   <= RES_W'(1) << (RES_W - 1);
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_CONVERT: begin
                    if (tick) begin
                        if (cancel_now) begin
                            state_q <= ST_SAMPLE;
                            cnt_q   <= '0;
                            sar_q   <= '0;
                            cpend_q <= 1'b0;
                        end else if (bit_q == '0) begin
                            sar_q   <= kept;
                            state_q <= ST_DONE;
                        end else begin
                            sar_q            <= kept | (RES_W'(1) << (bit_q - 1'b1));
                            bit_q            <= bit_q - 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    if (free_run) begin
                        state_q <= ST_SAMPLE;
                        cnt_q   <= '0;
                        sar_q   <= '0;
                        chan_o  <= chan_req;
                    end else begin
                        state_q  <= ST_IDLE;
                        pwr_down <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o        = state_q;
    assign trial_code     = sar_q;
    assign done_res.valid = (state_q == ST_DONE);
    assign done_res.value = sar_q;

    // R11: single-mode completion parks the converter powered down
    a_r11_pwr_after_single: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && !free_run) |=> (pwr_down && state_q == ST_IDLE));

    // R2: channel select never leaves the ten legal indices
    a_r2_chan_range: assert property (@(posedge clk) disable iff (rst)
        chan_o <= LAST_CH);

    // R1: without an enable, sampling and trials hold their state
    a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!tick && (state_q == ST_SAMPLE || state_q == ST_CONVERT))
        |=> ($stable(sar_q) && $stable(cnt_q) && $stable(state_q)));

    // R9: a queued request only exists while idle
    a_r9_pending_idle: assert property (@(posedge clk) disable iff (rst)
        pending |-> (state_q == ST_IDLE));

    // R10: a cancel is never carried into completion
    a_r10_no_cancel_at_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |-> !cpend_q);

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int SAMP_W  = 4,
    parameter int NUM_EXT = 3,
    localparam int SRC_W  = $clog2(NUM_EXT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIV_W-1:0]   div_ratio,
    input  logic [SAMP_W-1:0]  sample_len,
    input  logic [CH_W-1:0]    chan_sel,
    input  logic               free_run,
    input  logic [SRC_W-1:0]   trig_src,
    input  logic               sw_start,
    input  logic [NUM_EXT-1:0] ext_trig,
    input  logic               cancel,
    input  logic               cmp_in,
    input  logic               rd_en,
    input  logic [SCALE_W-1:0] scale,
    output logic [CH_W-1:0]    chan_out,
    output logic               sample_en,
    output logic [RES_W-1:0]   dac_code,
    output logic               pwr_down,
    output logic               busy,
    output logic               done_pulse,
    output logic               data_ready,
    output logic [RES_W-1:0]   rd_data
);
    logic             tick;
    logic             start_req;
    logic             pending;
    sar_state_e       state;
    sar_result_t      done_res;
    logic [RES_W-1:0] result_q;

    sar_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .div_ratio (div_ratio),
        .tick      (tick)
    );

    sar_trig_sel #(.NUM_EXT(NUM_EXT), .SRC_W(SRC_W)) u_trig (
        .trig_src  (trig_src),
        .sw_start  (sw_start),
        .ext_trig  (ext_trig),
        .start_req (start_req)
    );

    sar_core_fsm #(.SAMP_W(SAMP_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .start_req  (start_req),
        .cancel_req (cancel),
        .free_run   (free_run),
        .sample_len (sample_len),
        .chan_req   (clamp_chan(chan_sel)),
        .cmp_in     (cmp_in),
        .state_o    (state),
        .trial_code (dac_code),
        .chan_o     (chan_out),
        .pwr_down   (pwr_down),
        .pending    (pending),
        .done_res   (done_res)
    );

    assign sample_en = (state == ST_SAMPLE);
    assign busy      = (state != ST_IDLE) || pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q   <= '0;
            done_pulse <= 1'b0;
            data_ready <= 1'b0;
            rd_data    <= '0;
        end else begin
            done_pulse <= done_res.valid;
            if (done_res.valid) result_q <= done_res.value;
            if (rd_en) rd_data <= scale_shift(result_q, scale);
            if (done_res.valid)  data_ready <= 1'b1;
            else if (rd_en)      data_ready <= 1'b0;
        end
    end

    // R5: completion flag lasts a single clock
    a_r5_done_one_clock: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    // R5: completion and data-ready appear together
    a_r5_ready_with_done: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> data_ready);

    // R6: any non-zero scale leaves the top bit of the read value clear
    a_r6_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (rd_en && scale != '0) |=> !rd_data[RES_W-1]);

    // R4: the DAC sits at zero while the input is being sampled
    a_r4_quiet_dac: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> (dac_code == '0));

endmodule

// File: tb/sar_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sar_seq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_ratio = 8'd0;
    logic [3:0] sample_len = 4'd0;
    logic [3:0] chan_sel = 4'd0;
    logic       free_run = 1'b0;
    logic [1:0] trig_src = 2'd0;
    logic       sw_start = 1'b0;
    logic [2:0] ext_trig = 3'd0;
    logic       cancel = 1'b0;
    logic       cmp_in;
    logic       rd_en = 1'b0;
    logic [2:0] scale = 3'd0;
    logic [3:0] chan_out;
    logic       sample_en;
    logic [7:0] dac_code;
    logic       pwr_down, busy, done_pulse, data_ready;
    logic [7:0] rd_data;
    logic [7:0] vin = 8'd0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign cmp_in = (vin >= dac_code);

    sar_seq_ctrl u_sar_seq_ctrl (
        .clk(clk), .rst(rst), .div_ratio(div_ratio), .sample_len(sample_len),
        .chan_sel(chan_sel), .free_run(free_run), .trig_src(trig_src),
        .sw_start(sw_start), .ext_trig(ext_trig), .cancel(cancel),
        .cmp_in(cmp_in), .rd_en(rd_en), .scale(scale), .chan_out(chan_out),
        .sample_en(sample_en), .dac_code(dac_code), .pwr_down(pwr_down),
        .busy(busy), .done_pulse(done_pulse), .data_ready(data_ready),
        .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_sw();
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
    endtask

    task automatic wait_sample(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (sample_en) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_pulse) begin ok = 1'b1; break; end
        end
    endtask

    task automatic read_res(input logic [2:0] s, output logic [7:0] val);
        @(negedge clk) begin rd_en = 1'b1; scale = s; end
        @(negedge clk) rd_en = 1'b0;
        val = rd_data;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pwr_down == 1'b1, "R11 reset pwr_down", pwr_down, 1);
        chk(!busy && !sample_en && !done_pulse && !data_ready, "R12 reset flags",
            {busy, sample_en, done_pulse, data_ready}, 0);
        chk(dac_code == 0 && chan_out == 0 && rd_data == 0, "R12 reset data",
            dac_code + chan_out + rd_data, 0);
    endtask

    task automatic t_single(input logic [7:0] v, input logic [3:0] ch,
                            input int d, input int s);
        bit ok;
        int samp_clks, total;
        logic [7:0] r;
        logic [3:0] exp_ch;
        exp_ch = (ch > 4'd9) ? 4'd9 : ch;
        @(negedge clk) begin
            vin = v; chan_sel = ch; div_ratio = 8'(d); sample_len = 4'(s);
            free_run = 1'b0; trig_src = 2'd0;
        end
        pulse_sw();
        wait_sample(ok);
        chk(ok, "R7 single start", ok, 1);
        chk(pwr_down == 1'b0, "R11 pwr released", pwr_down, 0);
        chk(chan_out == exp_ch, "R2 channel", chan_out, exp_ch);
        samp_clks = 0; total = 0;
        while (sample_en && total < 20000) begin
            chk(dac_code == 0, "R4 dac zero in sample", dac_code, 0);
            samp_clks++; total++; @(negedge clk);
        end
        chk(dac_code == 8'h80, "R3 first trial", dac_code, 8'h80);
        while (!done_pulse && total < 20000) begin total++; @(negedge clk); end
        chk(samp_clks == (s + 1) * (d + 1), "R4 sample length", samp_clks, (s + 1) * (d + 1));
        chk(total == (s + 9) * (d + 1) + 1, "R1 conversion time", total, (s + 9) * (d + 1) + 1);
        chk(data_ready, "R5 data ready", data_ready, 1);
        @(negedge clk);
        chk(!done_pulse, "R5 single pulse", done_pulse, 0);
        chk(pwr_down && !busy, "R11 pwr after single", {pwr_down, busy}, 2);
        read_res(3'd0, r);
        chk(r == v, "R3 result", r, v);
        chk(!data_ready, "R6 ready cleared", data_ready, 0);
    endtask

    task automatic t_scale();
        logic [7:0] r, e;
        for (int s = 0; s < 8; s++) begin
            read_res(3'(s), r);
            e = 8'hB7 >> ((s > 6) ? 6 : s);
            chk(r == e, "R6 scaled read", r, e);
        end
    endtask

    task automatic t_trigger();
        bit ok;
        logic [7:0] r;
        @(negedge clk) begin trig_src = 2'd2; vin = 8'h3C; div_ratio = 8'd1; sample_len = 4'd1; end
        @(negedge clk) begin sw_start = 1'b1; ext_trig = 3'b101; end
        @(negedge clk) begin sw_start = 1'b0; ext_trig = 3'b000; end
        repeat (40) @(negedge clk);
        chk(!busy && pwr_down, "R8 other sources ignored", {busy, pwr_down}, 1);
        @(negedge clk) ext_trig = 3'b010;
        @(negedge clk) ext_trig = 3'b000;
        wait_done(ok);
        chk(ok, "R8 selected source starts", ok, 1);
        read_res(3'd0, r);
        chk(r == 8'h3C, "R8 result", r, 8'h3C);
        @(negedge clk) trig_src = 2'd0;
    endtask

    task automatic t_busy();
        bit ok;
        int seen;
        logic [7:0] r;
        @(negedge clk) begin vin = 8'h40; div_ratio = 8'd3; sample_len = 4'd2; end
        pulse_sw();
        wait_sample(ok);
        while (sample_en) @(negedge clk);
        pulse_sw();
        wait_done(ok);
        chk(ok, "R9 first conversion ends", ok, 1);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sample_en || busy) seen++;
        end
        chk(seen == 0, "R9 busy request ignored", seen, 0);
        read_res(3'd0, r);
        chk(r == 8'h40, "R9 result", r, 8'h40);
    endtask

    task automatic t_cancel();
        bit ok;
        int wait_clks, dones;
        logic [7:0] r;
        @(negedge clk) begin vin = 8'h11; div_ratio = 8'd2; sample_len = 4'd1; end
        pulse_sw();
        wait_sample(ok);
        while (sample_en) @(negedge clk);
        repeat (6) @(negedge clk);
        @(negedge clk) begin cancel = 1'b1; vin = 8'hE2; end
        @(negedge clk) cancel = 1'b0;
        wait_clks = 0; dones = 0;
        while (!sample_en && wait_clks < 50) begin
            if (done_pulse) dones++;
            wait_clks++; @(negedge clk);
        end
        chk(wait_clks <= 3, "R10 restart on next tick", wait_clks, 3);
        chk(dones == 0 && !data_ready, "R10 no completion", dones + data_ready, 0);
        wait_done(ok);
        chk(ok, "R10 restarted conversion ends", ok, 1);
        read_res(3'd0, r);
        chk(r == 8'hE2, "R10 fresh result", r, 8'hE2);
        @(negedge clk) cancel = 1'b1;
        @(negedge clk) cancel = 1'b0;
        repeat (20) @(negedge clk);
        chk(!busy && !sample_en && pwr_down, "R10 idle cancel ignored",
            {busy, sample_en, pwr_down}, 1);
    endtask

    task automatic t_freerun();
        bit ok;
        logic [7:0] r;
        logic [7:0] vals [3];
        vals[0] = 8'h9D; vals[1] = 8'h02; vals[2] = 8'hFE;
        @(negedge clk) begin
            free_run = 1'b1; chan_sel = 4'd12; div_ratio = 8'd1; sample_len = 4'd3; vin = vals[0];
        end
        pulse_sw();
        for (int i = 0; i < 3; i++) begin
            wait_done(ok);
            chk(ok, "R7 free-run completion", ok, 1);
            chk(sample_en, "R7 automatic restart", sample_en, 1);
            chk(!pwr_down, "R11 stays powered", pwr_down, 0);
            chk(chan_out == 4'd9, "R2 channel saturates", chan_out, 9);
            if (i < 2) vin = vals[i+1];
            read_res(3'd0, r);
            chk(r == vals[i], "R7 free-run result", r, vals[i]);
        end
        @(negedge clk) free_run = 1'b0;
        wait_done(ok);
        repeat (2) @(negedge clk);
        chk(pwr_down && !busy, "R11 stop after free-run", {pwr_down, busy}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single(8'h00, 4'd3, 0, 0);
        t_single(8'hFF, 4'd8, 3, 2);
        t_single(8'h5A, 4'd0, 5, 7);
        t_single(8'hB7, 4'd15, 1, 4);
        t_scale();
        t_trigger();
        t_busy();
        t_cancel();
        t_freerun();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule